// File: doc/BRIEF.md
# Segment display controller command and interrupt registers

This block is the register slice that starts, stops and resets a segment display driver and collects its two interrupt sources. Software writes one-shot commands to a control word. The block drives a run-request level to the waveform timing logic. It reports whether the driver is running and raises an interrupt line when an enabled event has been recorded. Waveform generation, the display memory and the mode, frame-rate and display registers belong to other slices.

A stop is not immediate. After a disable command the run request drops at once. The status bit keeps reporting "running" until the timing logic pulses `evHalted` to say the current frame has finished. That acknowledgement clears the status bit and records the halt interrupt. Interrupt masks are changed only through separate set and clear words. The recorded events clear when software reads them.

Top module: `lcd_reg_top`

## Requirements
- R1: After reset `ctrlEnable`, `swResetPulse` and `irq` are 0, and reads of offsets 0x10, 0x28 and 0x2C return 0.
- R2: A write to offset 0x00 with bit 0 set (enable) and bits 1 and 3 clear sets `ctrlEnable` on the next cycle. From then on, bit 0 of a read at offset 0x10 returns 1.
- R3: A write to offset 0x00 with bit 1 set (disable) while enabled clears `ctrlEnable` on the next cycle. Bit 0 at offset 0x10 stays 1 until an `evHalted` pulse. After that pulse it reads 0 and bit 2 at offset 0x2C reads 1.
- R4: A control write with both bit 0 and bit 1 set acts as a disable.
- R5: A control write with bits 0, 1 and 3 all clear changes nothing.
- R6: A control write with bit 3 set outranks every other input in that cycle. `swResetPulse` is then 1 for exactly one cycle, and in that cycle the enable, the running status, both mask bits and both event bits are 0.
- R7: At offset 0x20, a 1 in bit 0 or bit 2 sets that mask bit. At offset 0x24, a 1 in bit 0 or bit 2 clears that mask bit. Zeros in either word have no effect. The mask reads back at offset 0x28 in bits 0 (frame end) and 2 (halt).
- R8: An `evFrameEnd` pulse sets bit 0 at offset 0x2C. A read of 0x2C returns the bits and clears them at the end of that cycle. An event arriving in the cycle of the read leaves its bit set.
- R9: `irq` is 1 exactly when some event bit is set together with its mask bit.
- R10: An `evHalted` pulse while no stop is pending changes neither the running status nor the halt event bit.
- R11: Reads of any other offset return 0. `busRdata` is 0 when `busRead` is low. Writes to offsets 0x10, 0x28 and 0x2C have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWrite | input | 1 | Write strobe, one cycle per write |
| busWdata | input | DATA_W | Write data |
| busRead | input | 1 | Read strobe; data returned in the same cycle |
| busRdata | output | DATA_W | Read data |
| evFrameEnd | input | 1 | One-cycle pulse at each frame end |
| evHalted | input | 1 | One-cycle pulse when the timing logic has stopped |
| ctrlEnable | output | 1 | Run request to the timing logic |
| swResetPulse | output | 1 | One-cycle software reset to the rest of the controller |
| irq | output | 1 | Combined interrupt line |

## Verification
The bench builds the block with its default widths: an 8-bit offset and 32-bit data. With an 8-bit offset, every decoded word and a spread of unused offsets such as 0x04 and 0x30 can be reached directly. Those unused offsets exercise the zero-read and ignored-write paths. The 32-bit data width lets command words combine enable, disable and reset bits in one write. That brings the priority cases within reach, along with events that coincide with a status read or a reset.

// File: rtl/lcd_reg_pkg.sv
package lcd_reg_pkg;

  // command bit positions in the control word
  localparam int CMD_EN_BIT  = 0;
  localparam int CMD_DIS_BIT = 1;
  localparam int CMD_RST_BIT = 3;

  // interrupt sources and their bit positions in the interrupt words
  localparam int NUM_SRC   = 2;
  localparam int FRAME_BIT = 0;
  localparam int HALT_BIT  = 2;

  // word offsets
  localparam int OFS_CTRL   = 'h00;
  localparam int OFS_STATUS = 'h10;
  localparam int OFS_IE     = 'h20;
  localparam int OFS_ID     = 'h24;
  localparam int OFS_MASK   = 'h28;
  localparam int OFS_ISR    = 'h2C;

  typedef logic [NUM_SRC-1:0] srcVec_t;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_MASK,
    SEL_ISR
  } readSel_t;

  typedef struct packed {
    logic    cmdEnable;
    logic    cmdDisable;
    logic    cmdSwReset;
    srcVec_t maskSet;
    srcVec_t maskClr;
    logic    readIsr;
  } regStrobe_t;

  function automatic int srcPos(input int idx);
    return (idx == 0) ? FRAME_BIT : HALT_BIT;
  endfunction

endpackage

// File: rtl/lcd_reg_decode.sv
module lcd_reg_decode
  import lcd_reg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busRead,
  output regStrobe_t        strobe,
  output readSel_t          readSel
);

  logic hitCtrl, hitStatus, hitIe, hitId, hitMask, hitIsr;

  always_comb begin
    hitCtrl   = (busAddr == ADDR_W'(OFS_CTRL));
    hitStatus = (busAddr == ADDR_W'(OFS_STATUS));
    hitIe     = (busAddr == ADDR_W'(OFS_IE));
    hitId     = (busAddr == ADDR_W'(OFS_ID));
    hitMask   = (busAddr == ADDR_W'(OFS_MASK));
    hitIsr    = (busAddr == ADDR_W'(OFS_ISR));
  end

  always_comb begin
    strobe.cmdEnable  = busWrite && hitCtrl && busWdata[CMD_EN_BIT];
    strobe.cmdDisable = busWrite && hitCtrl && busWdata[CMD_DIS_BIT];
    strobe.cmdSwReset = busWrite && hitCtrl && busWdata[CMD_RST_BIT];
    strobe.readIsr    = busRead && hitIsr;
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam int POS = srcPos(s);
    assign strobe.maskSet[s] = busWrite && hitIe && busWdata[POS];
    assign strobe.maskClr[s] = busWrite && hitId && busWdata[POS];
  end

  always_comb begin
    readSel = SEL_NONE;
    if (busRead) begin
      if (hitStatus)    readSel = SEL_STATUS;
      else if (hitMask) readSel = SEL_MASK;
      else if (hitIsr)  readSel = SEL_ISR;
    end
  end

endmodule

// File: rtl/lcd_reg_state.sv
module lcd_reg_state
  import lcd_reg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  readSel_t          readSel,
  input  logic              evFrameEnd,
  input  logic              evHalted,
  output logic              ctrlEnable,
  output logic              swResetPulse,
  output logic              irq,
  output logic [DATA_W-1:0] busRdata
);

  logic    runReq, enaStatus, stopping, swQ;
  srcVec_t maskQ, statQ, evVec;
  logic    runN, enaN, stopN;

  always_comb begin
    evVec    = '0;
    evVec[0] = evFrameEnd;
    evVec[1] = evHalted && stopping;
  end

  // command sequencing: halt acknowledgement first, then the written command
  always_comb begin
    runN  = runReq;
    enaN  = enaStatus;
    stopN = stopping;
    if (evVec[1]) begin
      enaN  = 1'b0;
      stopN = 1'b0;
    end
    if (strobe.cmdDisable) begin
      if (runReq) begin
        runN  = 1'b0;
        stopN = 1'b1;
      end
    end else if (strobe.cmdEnable) begin
      runN  = 1'b1;
      enaN  = 1'b1;
      stopN = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runReq    <= 1'b0;
      enaStatus <= 1'b0;
      stopping  <= 1'b0;
      maskQ     <= '0;
      statQ     <= '0;
      swQ       <= 1'b0;
    end else if (strobe.cmdSwReset) begin
      runReq    <= 1'b0;
      enaStatus <= 1'b0;
      stopping  <= 1'b0;
      maskQ     <= '0;
      statQ     <= '0;
      swQ       <= 1'b1;
    end else begin
      runReq    <= runN;
      enaStatus <= enaN;
      stopping  <= stopN;
      maskQ     <= (maskQ | strobe.maskSet) & ~strobe.maskClr;
      statQ     <= (strobe.readIsr ? srcVec_t'(0) : statQ) | evVec;
      swQ       <= 1'b0;
    end
  end

  function automatic logic [DATA_W-1:0] spread(input srcVec_t v);
    logic [DATA_W-1:0] w;
    w = '0;
    for (int s = 0; s < NUM_SRC; s++) w[srcPos(s)] = v[s];
    return w;
  endfunction

  always_comb begin
    case (readSel)
      SEL_STATUS: busRdata = DATA_W'(enaStatus);
      SEL_MASK:   busRdata = spread(maskQ);
      SEL_ISR:    busRdata = spread(statQ);
      default:    busRdata = '0;
    endcase
  end

  assign ctrlEnable   = runReq;
  assign swResetPulse = swQ;
  assign irq          = |(statQ & maskQ);

  assert_swrst_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    swQ |-> (!runReq && !enaStatus && maskQ == '0 && statQ == '0));

  assert_swrst_source_R6: assert property (@(posedge clk) disable iff (!rstN)
    swQ |-> $past(strobe.cmdSwReset));

  assert_enable_rise_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cmdEnable && !strobe.cmdDisable && !strobe.cmdSwReset) |=> (runReq && enaStatus));

  assert_disable_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cmdDisable && !strobe.cmdSwReset) |=> !runReq);

  assert_halt_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statQ[1]) |-> $past(stopping && evHalted));

  assert_read_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.readIsr && !evFrameEnd && !strobe.cmdSwReset) |=> !statQ[0]);

endmodule

// File: rtl/lcd_reg_top.sv
module lcd_reg_top
  import lcd_reg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busRead,
  output logic [DATA_W-1:0] busRdata,
  input  logic              evFrameEnd,
  input  logic              evHalted,
  output logic              ctrlEnable,
  output logic              swResetPulse,
  output logic              irq
);

  regStrobe_t strobe;
  readSel_t   readSel;

  lcd_reg_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_decode (
    .busAddr (busAddr),
    .busWrite(busWrite),
    .busWdata(busWdata),
    .busRead (busRead),
    .strobe  (strobe),
    .readSel (readSel)
  );

  lcd_reg_state #(.DATA_W(DATA_W)) i_state (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .readSel     (readSel),
    .evFrameEnd  (evFrameEnd),
    .evHalted    (evHalted),
    .ctrlEnable  (ctrlEnable),
    .swResetPulse(swResetPulse),
    .irq         (irq),
    .busRdata    (busRdata)
  );

endmodule

// File: tb/test_lcd_reg_top.sv
`timescale 1ns/1ps
module test_lcd_reg_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrite = 1'b0;
  logic [31:0] busWdata = '0;
  logic        busRead = 1'b0;
  logic [31:0] busRdata;
  logic        evFrameEnd = 1'b0;
  logic        evHalted = 1'b0;
  logic        ctrlEnable, swResetPulse, irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  lcd_reg_top i_lcd_reg_top (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busWdata(busWdata), .busRead(busRead), .busRdata(busRdata),
    .evFrameEnd(evFrameEnd), .evHalted(evHalted), .ctrlEnable(ctrlEnable),
    .swResetPulse(swResetPulse), .irq(irq)
  );

  // behavioural reference model
  bit       mEn, mEna, mStop, mSw;
  bit [1:0] mMask, mStat;

  always @(posedge clk) begin
    bit [1:0] nStat;
    if (!rstN) begin
      mEn = 0; mEna = 0; mStop = 0; mSw = 0; mMask = 0; mStat = 0;
    end else if (busWrite && busAddr == 8'h00 && busWdata[3]) begin
      mEn = 0; mEna = 0; mStop = 0; mSw = 1; mMask = 0; mStat = 0;
    end else begin
      mSw = 0;
      nStat = (busRead && busAddr == 8'h2C) ? 2'b00 : mStat;
      if (evFrameEnd) nStat[0] = 1;
      if (evHalted && mStop) begin nStat[1] = 1; mEna = 0; mStop = 0; end
      mStat = nStat;
      if (busWrite && busAddr == 8'h00) begin
        if (busWdata[1]) begin
          if (mEn) begin mEn = 0; mStop = 1; end
        end else if (busWdata[0]) begin
          mEn = 1; mEna = 1; mStop = 0;
        end
      end
      if (busWrite && busAddr == 8'h20) mMask = mMask | {busWdata[2], busWdata[0]};
      if (busWrite && busAddr == 8'h24) mMask = mMask & ~{busWdata[2], busWdata[0]};
    end
  end

  function automatic logic [31:0] expRd();
    if (!busRead) return 32'h0;
    case (busAddr)
      8'h10:   return {31'b0, mEna};
      8'h28:   return {29'b0, mMask[1], 1'b0, mMask[0]};
      8'h2C:   return {29'b0, mStat[1], 1'b0, mStat[0]};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (rstN) begin
      check("R2 ctrlEnable model", {31'b0, ctrlEnable}, {31'b0, mEn});
      check("R6 swResetPulse model", {31'b0, swResetPulse}, {31'b0, mSw});
      check("R9 irq model", {31'b0, irq}, {31'b0, |(mStat & mMask)});
      check("R8 busRdata model", busRdata, expRd());
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk); busWrite = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; busRead = 1'b1;
    #2 d = busRdata;
    @(negedge clk); busRead = 1'b0;
  endtask

  task automatic pulseFrame();
    @(negedge clk); evFrameEnd = 1'b1;
    @(negedge clk); evFrameEnd = 1'b0;
  endtask

  task automatic pulseHalt();
    @(negedge clk); evHalted = 1'b1;
    @(negedge clk); evHalted = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #2;
    // R1 reset state
    check("R1 ctrlEnable", {31'b0, ctrlEnable}, 0);
    check("R1 swResetPulse", {31'b0, swResetPulse}, 0);
    check("R1 irq", {31'b0, irq}, 0);
    rd(8'h10, v); check("R1 status", v, 0);
    rd(8'h28, v); check("R1 mask", v, 0);
    rd(8'h2C, v); check("R1 isr", v, 0);

    // R5 zero command while idle
    wr(8'h00, 32'h0); #2 check("R5 idle zero write", {31'b0, ctrlEnable}, 0);
    // R2 enable
    wr(8'h00, 32'h1); #2 check("R2 enable", {31'b0, ctrlEnable}, 1);
    rd(8'h10, v); check("R2 status running", v, 1);
    // R5 zero command while running
    wr(8'h00, 32'h0); #2 check("R5 running zero write", {31'b0, ctrlEnable}, 1);

    // R7 mask set, R9 irq
    wr(8'h20, 32'h1); rd(8'h28, v); check("R7 mask set bit0", v, 1);
    #2 check("R9 no event no irq", {31'b0, irq}, 0);
    pulseFrame(); #2 check("R9 frame irq", {31'b0, irq}, 1);
    rd(8'h2C, v); check("R8 frame event", v, 1);
    rd(8'h2C, v); check("R8 cleared by read", v, 0);
    #2 check("R9 irq after clear", {31'b0, irq}, 0);

    // R8 event in the same cycle as the read
    @(negedge clk); busAddr = 8'h2C; busRead = 1'b1; evFrameEnd = 1'b1;
    #2 v = busRdata; check("R8 read value during event", v, 0);
    @(negedge clk); busRead = 1'b0; evFrameEnd = 1'b0;
    rd(8'h2C, v); check("R8 event wins over read", v, 1);
    rd(8'h2C, v); check("R8 second read", v, 0);

    // R10 halt without pending stop
    pulseHalt();
    rd(8'h2C, v); check("R10 no halt event", v, 0);
    rd(8'h10, v); check("R10 still running", v, 1);

    // R4 enable and disable together, R3 completion
    wr(8'h00, 32'h3); #2 check("R4 disable wins", {31'b0, ctrlEnable}, 0);
    rd(8'h10, v); check("R3 running until halt", v, 1);
    pulseHalt();
    rd(8'h10, v); check("R3 stopped after halt", v, 0);
    rd(8'h2C, v); check("R3 halt event", v, 4);

    // R7 more mask cases
    wr(8'h20, 32'h4); rd(8'h28, v); check("R7 mask set bit2", v, 5);
    pulseFrame(); #2 check("R9 frame irq again", {31'b0, irq}, 1);
    wr(8'h24, 32'h0); rd(8'h28, v); check("R7 zero clear no effect", v, 5);
    wr(8'h24, 32'h1); rd(8'h28, v); check("R7 clear bit0", v, 4);
    #2 check("R9 masked event no irq", {31'b0, irq}, 0);

    // R11 read-only and unused offsets
    wr(8'h2C, 32'h5); wr(8'h10, 32'h1); wr(8'h28, 32'h1);
    rd(8'h10, v); check("R11 status write ignored", v, 0);
    rd(8'h28, v); check("R11 mask word write ignored", v, 4);
    rd(8'h2C, v); check("R11 isr write ignored", v, 1);
    rd(8'h04, v); check("R11 unused 0x04", v, 0);
    rd(8'h30, v); check("R11 unused 0x30", v, 0);
    #2 check("R11 idle bus reads zero", busRdata, 0);

    // R6 software reset with enable in the same word
    wr(8'h00, 32'h1); wr(8'h20, 32'h1); pulseFrame();
    #2 check("R6 irq before reset", {31'b0, irq}, 1);
    wr(8'h00, 32'h9);
    #2 check("R6 pulse high", {31'b0, swResetPulse}, 1);
    check("R6 enable cleared", {31'b0, ctrlEnable}, 0);
    check("R6 irq cleared", {31'b0, irq}, 0);
    @(negedge clk); #2 check("R6 pulse single cycle", {31'b0, swResetPulse}, 0);
    rd(8'h10, v); check("R6 status cleared", v, 0);
    rd(8'h28, v); check("R6 mask cleared", v, 0);
    rd(8'h2C, v); check("R6 events cleared", v, 0);

    repeat (3) @(negedge clk);
    summary();
  end

endmodule